// File: doc/BRIEF.md
# Pipelined BCD to Densely Packed Decimal Compressor

This block packs three binary-coded decimal digits (a 12-bit word, hundreds digit in the top nibble) into a single 10-bit densely packed decimal declet. The conversion is a fixed set of sum-of-products equations. It is cut into three register stages: an inversion stage that registers the raw digits together with the complements of the three digit top bits, an AND stage that registers every product term, and an OR stage that combines the terms into the declet. Each stage therefore holds one gate level of logic. All pipeline registers capture on the falling clock edge.

A new word is accepted on every falling edge that sees the input strobe high. Its declet appears after the second falling edge that follows, together with a matching output strobe. The three declet bits that are plain copies of the lowest bit of each digit pass through delay flops, so that they stay aligned with the computed bits of the same word. A stage loads only when the word it would receive is valid, so the declet output keeps its last value while no valid word reaches it. Input nibbles above 9 give an unspecified declet.

Top module: `bcd_declet_packer`

## Requirements
- R1: While reset is high on a falling edge, every pipeline register clears: after that edge `outValid` is 0 and `outDeclet` is 0, and `outValid` stays 0 for the first two falling edges after reset is released.
- R2: For every legal input (three nibbles each 0 to 9, hundreds in bits 11:8, tens in 7:4, units in 3:0), `outDeclet` equals the densely packed decimal encoding of that value, whose bits 3:1 give the case: bit 3 = 0 means all digits are small (0 to 7); bits 3:1 = 100 units large, 101 tens large, 110 hundreds large, 111 two or more digits large, with bits 6:5 then choosing which (00 hundreds and tens, 01 hundreds and units, 10 tens and units, 11 all three).
- R3: For values 0 to 79 the declet equals the low 10 bits of the BCD input.
- R4: A word sampled on falling edge N appears on `outDeclet` with `outValid` high after falling edge N+2; `outValid` after an edge equals the input strobe three edges earlier.
- R5: Words presented on consecutive edges come out on consecutive edges with `outValid` high throughout, with no stall or bubble.
- R6: Declet bits 7, 4 and 0 equal BCD bits 8, 4 and 0 of the same word.
- R7: When no valid word reaches the output stage, `outValid` is 0 and `outDeclet` holds its previous value.
- R8: Input 0x099 gives declet 0x05F, and input 0x999 gives declet 0x0FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers capture on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | High when `inBcd` carries a word to convert |
| inBcd | input | 12 | Three BCD digits, hundreds in the top nibble |
| outValid | output | 1 | High when `outDeclet` carries a new result |
| outDeclet | output | 10 | Densely packed decimal declet |

## Verification
The hardest situation to reach from the ports is the one where every large/small digit combination arrives back to back, so that each product term switches on and off on successive edges while the delayed copy bits must stay aligned with their own word. The stimulus drives all 1000 legal values on consecutive cycles, from 000 up to 999, with no gap. This crosses every case boundary of the encoding at full rate. Gapped traffic and a lone word after idle cycles then expose the strobe latency and the hold behaviour.

// File: rtl/declet_pkg.sv
package declet_pkg;
  localparam int NIB        = 4;
  localparam int DIGITS     = 3;
  localparam int BCD_W      = NIB * DIGITS;
  localparam int DECLET_W   = 10;
  localparam int PIPE_DEPTH = 3;

  // input bit positions of the digit top bits
  localparam int POS_A = BCD_W - 1;
  localparam int POS_E = 2 * NIB - 1;
  localparam int POS_I = NIB - 1;

  // the two symmetric output lanes (p/s and q/t)
  localparam int LANES    = 2;
  localparam int PQ_TERMS = 3;
  localparam int ST_TERMS = 4;
  localparam int VWX_TERMS = 3;
  localparam int PASS_BITS = DIGITS;

  // declet bit positions
  localparam int DEC_P = 9;
  localparam int DEC_S = 6;
  localparam int DEC_V = 3;
  localparam int DEC_W = 2;
  localparam int DEC_X = 1;

  typedef struct packed {
    logic loadPre;
    logic loadAnd;
    logic loadOr;
  } stageStrobes_t;

  // source bit of pass-through copy g: lowest bit of digit g (hundreds first)
  function automatic int passSrc(input int g);
    return NIB * (DIGITS - 1 - g);
  endfunction

  // destination declet bit of pass-through copy g
  function automatic int passDst(input int g);
    return (g == 0) ? 7 : ((g == 1) ? 4 : 0);
  endfunction
endpackage

// File: rtl/declet_ctrl.sv
module declet_ctrl
  import declet_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output stageStrobes_t strobes,
  output logic          outValid
);
  logic [PIPE_DEPTH-1:0] validPipe;

  always_ff @(negedge clk) begin
    if (rst) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[PIPE_DEPTH-2:0], inValid};
    end
  end

  always_comb begin
    strobes.loadPre = inValid;
    strobes.loadAnd = validPipe[0];
    strobes.loadOr  = validPipe[1];
  end

  assign outValid = validPipe[PIPE_DEPTH-1];
endmodule

// File: rtl/declet_datapath.sv
module declet_datapath
  import declet_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  stageStrobes_t       strobes,
  input  logic [BCD_W-1:0]    inBcd,
  output logic [DECLET_W-1:0] outDeclet
);
  // ---------------- stage 1: raw digits and inverted top bits
  logic [BCD_W-1:0] rawQ;
  logic invAQ, invEQ, invIQ;

  always_ff @(negedge clk) begin
    if (rst) begin
      rawQ  <= '0;
      invAQ <= 1'b0;
      invEQ <= 1'b0;
      invIQ <= 1'b0;
    end else if (strobes.loadPre) begin
      rawQ  <= inBcd;
      invAQ <= ~inBcd[POS_A];
      invEQ <= ~inBcd[POS_E];
      invIQ <= ~inBcd[POS_I];
    end
  end

  logic bitA, bitE, bitI;
  assign bitA = rawQ[POS_A];
  assign bitE = rawQ[POS_E];
  assign bitI = rawQ[POS_I];

  // ---------------- stage 2: product terms
  logic [PQ_TERMS-1:0]  pqNext [LANES];
  logic [ST_TERMS-1:0]  stNext [LANES];
  logic [VWX_TERMS-1:0] vNext, wNext, xNext;
  logic [PASS_BITS-1:0] passNext;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int HUN = POS_A - 1 - l;
    localparam int TEN = POS_E - 1 - l;
    localparam int UNI = POS_I - 1 - l;
    assign pqNext[l][0] = invAQ & rawQ[HUN];
    assign pqNext[l][1] = bitA & rawQ[UNI] & invIQ;
    assign pqNext[l][2] = bitA & rawQ[TEN] & bitI & invEQ;
    assign stNext[l][0] = rawQ[TEN] & invEQ & invIQ;
    assign stNext[l][1] = rawQ[TEN] & invAQ & invEQ;
    assign stNext[l][2] = rawQ[UNI] & invAQ & bitE & invIQ;
    if (l == 0) begin : g_left
      assign stNext[l][3] = bitE & bitI;
    end else begin : g_right
      assign stNext[l][3] = bitA & bitI;
    end
  end

  assign vNext = {bitA, bitE, bitI};
  assign wNext = {bitA, bitE & bitI, invEQ & rawQ[POS_I-1] & invIQ};
  assign xNext = {bitE, bitA & bitI, invAQ & rawQ[POS_I-2] & invIQ};

  for (genvar g = 0; g < PASS_BITS; g++) begin : g_passAnd
    assign passNext[g] = rawQ[passSrc(g)];
  end

  logic [PQ_TERMS-1:0]  pqQ [LANES];
  logic [ST_TERMS-1:0]  stQ [LANES];
  logic [VWX_TERMS-1:0] vQ, wQ, xQ;
  logic [PASS_BITS-1:0] passQ;

  always_ff @(negedge clk) begin
    if (rst) begin
      for (int l = 0; l < LANES; l++) begin
        pqQ[l] <= '0;
        stQ[l] <= '0;
      end
      vQ    <= '0;
      wQ    <= '0;
      xQ    <= '0;
      passQ <= '0;
    end else if (strobes.loadAnd) begin
      for (int l = 0; l < LANES; l++) begin
        pqQ[l] <= pqNext[l];
        stQ[l] <= stNext[l];
      end
      vQ    <= vNext;
      wQ    <= wNext;
      xQ    <= xNext;
      passQ <= passNext;
    end
  end

  // ---------------- stage 3: OR combine
  logic [DECLET_W-1:0] decletNext;

  always_comb begin
    decletNext = '0;
    for (int l = 0; l < LANES; l++) begin
      decletNext[DEC_P-l] = |pqQ[l];
      decletNext[DEC_S-l] = |stQ[l];
    end
    decletNext[DEC_V] = |vQ;
    decletNext[DEC_W] = |wQ;
    decletNext[DEC_X] = |xQ;
    for (int g = 0; g < PASS_BITS; g++) begin
      decletNext[passDst(g)] = passQ[g];
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      outDeclet <= '0;
    end else if (strobes.loadOr) begin
      outDeclet <= decletNext;
    end
  end
endmodule

// File: rtl/bcd_declet_packer.sv
module bcd_declet_packer
  import declet_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [BCD_W-1:0]    inBcd,
  output logic                outValid,
  output logic [DECLET_W-1:0] outDeclet
);
  stageStrobes_t strobes;

  declet_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  declet_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .inBcd     (inBcd),
    .outDeclet (outDeclet)
  );
endmodule

// File: rtl/declet_packer_checker.sv
module declet_packer_checker
  import declet_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic [BCD_W-1:0]    inBcd,
  input logic                outValid,
  input logic [DECLET_W-1:0] outDeclet
);
  // edges since reset release, saturating at the pipeline depth
  logic [1:0] sinceRst;
  always_ff @(negedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_reset_clear_R1: assert property (@(negedge clk)
    $past(rst) |-> (!outValid && outDeclet == '0));

  assert_no_early_valid_R1: assert property (@(negedge clk) disable iff (rst)
    (sinceRst != 2'd3) |-> !outValid);

  assert_valid_latency_R4: assert property (@(negedge clk) disable iff (rst)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  assert_copy_bits_R6: assert property (@(negedge clk) disable iff (rst)
    (sinceRst == 2'd3 && $past(inValid, 3)) |->
      ({outDeclet[7], outDeclet[4], outDeclet[0]} ==
       $past({inBcd[8], inBcd[4], inBcd[0]}, 3)));

  assert_low_range_R3: assert property (@(negedge clk) disable iff (rst)
    (sinceRst == 2'd3 && $past(inValid && inBcd[11:7] == 5'd0, 3)) |->
      (outDeclet == $past(inBcd[9:0], 3)));

  assert_hold_idle_R7: assert property (@(negedge clk) disable iff (rst)
    !outValid |-> $stable(outDeclet));
endmodule

bind bcd_declet_packer declet_packer_checker u_chk (.*);

// File: tb/bcd_declet_packer_bench.sv
module bcd_declet_packer_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       inValid;
  logic [11:0] inBcd;
  logic       outValid;
  logic [9:0] outDeclet;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [9:0] lastExp = '0;
  bit hv [0:2047];
  int hn [0:2047];

  always #2 clk = ~clk;  // 250 MHz

  bcd_declet_packer u_bcd_declet_packer (
    .clk(clk), .rst(rst), .inValid(inValid), .inBcd(inBcd),
    .outValid(outValid), .outDeclet(outDeclet)
  );

  function automatic logic [11:0] toBcd(input int n);
    return {4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  function automatic logic [9:0] refPack(input int n);
    logic [3:0] d2, d1, d0;
    d2 = 4'(n / 100); d1 = 4'((n / 10) % 10); d0 = 4'(n % 10);
    case ({d2[3], d1[3], d0[3]})
      3'b000: return {d2[2:0], d1[2:0], 1'b0, d0[2:0]};
      3'b001: return {d2[2:0], d1[2:0], 1'b1, 2'b00, d0[0]};
      3'b010: return {d2[2:0], d0[2:1], d1[0], 1'b1, 2'b01, d0[0]};
      3'b100: return {d0[2:1], d2[0], d1[2:0], 1'b1, 2'b10, d0[0]};
      3'b110: return {d0[2:1], d2[0], 2'b00, d1[0], 3'b111, d0[0]};
      3'b101: return {d1[2:1], d2[0], 2'b01, d1[0], 3'b111, d0[0]};
      3'b011: return {d2[2:0], 2'b10, d1[0], 3'b111, d0[0]};
      default: return {2'b00, d2[0], 2'b11, d1[0], 3'b111, d0[0]};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", req, cyc, act, expv);
    end
  endtask

  // one cycle: check the result due now, then present the next word
  task automatic step(input bit v, input int n, input bit burst);
    logic [9:0] expDec;
    bit expV;
    int src;
    @(posedge clk);
    expV = 1'b0;
    expDec = lastExp;
    src = 0;
    if (cyc >= 3 && hv[cyc-3]) begin
      src = hn[cyc-3];
      expV = 1'b1;
      expDec = refPack(src);
      lastExp = expDec;
    end
    if (burst && expV) check(outValid == 1'b1, "R5", int'(outValid), 1);
    else check(outValid == expV, "R4", int'(outValid), int'(expV));
    if (expV) begin
      check(outDeclet == expDec, (src < 80) ? "R3" : "R2", int'(outDeclet), int'(expDec));
      check({outDeclet[7], outDeclet[4], outDeclet[0]} ==
            {toBcd(src)[8], toBcd(src)[4], toBcd(src)[0]}, "R6",
            int'({outDeclet[7], outDeclet[4], outDeclet[0]}),
            int'({toBcd(src)[8], toBcd(src)[4], toBcd(src)[0]}));
      if (src == 99)  check(outDeclet == 10'h05F, "R8", int'(outDeclet), 'h05F);
      if (src == 999) check(outDeclet == 10'h0FF, "R8", int'(outDeclet), 'h0FF);
    end else begin
      check(outDeclet == expDec, "R7", int'(outDeclet), int'(expDec));
    end
    hv[cyc] = v;
    hn[cyc] = n;
    inValid = v;
    inBcd = toBcd(n);
    cyc++;
  endtask

  initial begin
    for (int k = 0; k < 2048; k++) begin hv[k] = 1'b0; hn[k] = 0; end
    rst = 1'b1;
    inValid = 1'b1;
    inBcd = 12'h999;
    repeat (4) @(posedge clk);
    // R1: reset wins over a valid word
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    check(outDeclet == 10'd0, "R1", int'(outDeclet), 0);
    inValid = 1'b0;
    @(posedge clk);
    rst = 1'b0;
    // R1: nothing valid in the first cycles after release
    step(1'b0, 0, 1'b0);
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    step(1'b0, 0, 1'b0);
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    // R2 R3 R5 R6 R8: full sweep back to back
    for (int n = 0; n < 1000; n++) step(1'b1, n, 1'b1);
    // R7: idle, output must hold the declet of 999
    for (int k = 0; k < 6; k++) step(1'b0, 0, 1'b1);
    // R4: lone word after idle
    step(1'b1, 99, 1'b0);
    for (int k = 0; k < 5; k++) step(1'b0, 0, 1'b0);
    // R7 R4: gapped traffic
    for (int n = 850; n < 890; n++) step((n % 3) != 0, n, 1'b0);
    for (int k = 0; k < 5; k++) step(1'b0, 0, 1'b0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule